// File: doc/BRIEF.md
# Maskable interrupt flag controller

This block collects single-cycle event pulses from surrounding logic (frame reception, radio link, NFC wake-up and the firmware update path) into a register of eight sticky flags. A seven-bit enable mask chooses which of those flags may raise a single active-high interrupt pin towards the host. The host reads both registers, clears flags by writing ones to them, and reprograms the mask. The event sources and the serial command decoding sit outside the block.

The flag positions are fixed: bit 0 means the system has restarted, bit 1 a new DMX frame, bit 2 a complete RDM frame, bit 3 an NFC wake-up, bit 4 a radio link change, bit 5 an update start request, bit 6 an update packet waiting, and bit 7 the end of an update. Mask bit j enables flag bit j+1, so the mask is offset by one position. The restart flag has no mask bit and never reaches the pin.

The pin is driven by a two-state machine. State IRQ_IDLE (pin low) moves to IRQ_ACTIVE on transition RAISE when any enabled flag is pending. State IRQ_ACTIVE (pin high) moves back to IRQ_IDLE on transition DROP when no enabled flag is pending. Otherwise each state holds (transitions STAY_IDLE and STAY_ACTIVE).

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, flags_o is 8'h01 (only the restart flag set), mask_o is 7'h7F and irq_o is 0.
- R2: A 1 on evt_i[k] sets flags_o[k] at the next clock edge, and the flag stays set until the host clears it. Bit map: 0 restart, 1 DMX frame, 2 complete RDM frame, 3 NFC wake-up, 4 radio link change, 5 update start, 6 update packet, 7 update stop.
- R3: A write with wr_sel = 0 clears every flag whose wr_data bit is 1 and leaves every flag whose wr_data bit is 0 unchanged.
- R4: If an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: A write with wr_sel = 1 loads mask_o from wr_data[6:0], and wr_data[7] is ignored. Mask bit j enables flag bit j+1.
- R6: irq_o is the registered OR of flags_o[j+1] AND mask_o[j] over j = 0..6. It reflects the flag and mask values one clock edge after they change.
- R7: The restart flag (bit 0) never drives irq_o, whatever the mask holds.
- R8: A write with wr_en = 0, or a write to the other register, leaves that register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | Event pulses, one per flag bit |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 1 | 0 selects the flag register, 1 selects the mask register |
| wr_data | input | 8 | Host write data |
| flags_o | output | 8 | Current flag register |
| mask_o | output | 7 | Current enable mask |
| irq_o | output | 1 | Active-high interrupt pin |

## Verification
The bench targets the off-by-one mapping between mask and flags. It walks each event with only its matching mask bit enabled, so a design with unshifted mask bits leaves the pin low or raises it for the wrong flag. It clears and sets the same flag in one cycle; a design where the clear wins loses the event. It writes zero bits to the flag register, which a design that loads the register instead of clearing it would wipe out. It also sets only the restart flag with every mask bit on, where a design that ORs in bit 0 would raise the pin. It measures the pin's one-cycle lag after each change, so a combinational or doubly registered pin shows up.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;

    localparam int RESTART_BIT = 0;

endpackage

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
    parameter int NUM_FLAGS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] evt_i,
    input  logic                 clr_en,
    input  logic [NUM_FLAGS-1:0] clr_bits,
    output logic [NUM_FLAGS-1:0] flags_q
);
    import irq_pkg::*;

    localparam logic [NUM_FLAGS-1:0] FLAG_RST = NUM_FLAGS'(1) << RESTART_BIT;

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
        logic flag_d;

        always_comb begin
            flag_d = flags_q[k];
            if (clr_en && clr_bits[k]) begin
                flag_d = 1'b0;
            end
            if (evt_i[k]) begin
                flag_d = 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags_q[k] <= FLAG_RST[k];
            end else begin
                flags_q[k] <= flag_d;
            end
        end
    end

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((flags_q & $past(evt_i)) == $past(evt_i))); // R4

    AST_NO_SPURIOUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R8

    AST_ZERO_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((flags_q & $past(flags_q & ~clr_bits)) == $past(flags_q & ~clr_bits))); // R3

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int MASK_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [MASK_W-1:0] load_val,
    output logic [MASK_W-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (load_en) begin
            mask_q <= load_val;
        end
    end

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(mask_q)); // R8

endmodule

// File: rtl/irq_pin_fsm.sv
module irq_pin_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq_o
);
    import irq_pkg::*;

    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pending)  state_d = IRQ_ACTIVE; // RAISE
            IRQ_ACTIVE: if (!pending) state_d = IRQ_IDLE;   // DROP
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq_o = (state_q == IRQ_ACTIVE);
    end

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
    parameter int NUM_FLAGS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] evt_i,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [NUM_FLAGS-1:0] wr_data,
    output logic [NUM_FLAGS-1:0] flags_o,
    output logic [NUM_FLAGS-2:0] mask_o,
    output logic                 irq_o
);
    import irq_pkg::*;

    localparam int MASK_W = NUM_FLAGS - 1;

    logic flag_wr;
    logic mask_wr;
    logic pending;

    assign flag_wr = wr_en && !wr_sel;
    assign mask_wr = wr_en && wr_sel;

    irq_flag_reg #(.NUM_FLAGS(NUM_FLAGS)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .clr_en   (flag_wr),
        .clr_bits (wr_data),
        .flags_q  (flags_o)
    );

    irq_mask_reg #(.MASK_W(MASK_W)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (mask_wr),
        .load_val (wr_data[MASK_W-1:0]),
        .mask_q   (mask_o)
    );

    // Flag k+1 is gated by mask bit k; the restart flag is left out.
    assign pending = |(flags_o[NUM_FLAGS-1:1] & mask_o);

    irq_pin_fsm u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .irq_o   (irq_o)
    );

    AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_o[NUM_FLAGS-1:1] & mask_o) != '0) |=> irq_o); // R6

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_o[NUM_FLAGS-1:1] & mask_o) == '0) |=> !irq_o); // R7

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (mask_o == $past(wr_data[MASK_W-1:0]))); // R5

endmodule

// File: tb/irq_flag_ctrl_tb.sv
`timescale 1ns/1ps
module irq_flag_ctrl_tb;

    typedef struct {
        logic [7:0] flags;
        logic [6:0] mask;
        logic       irq;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_i = '0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] flags_o;
    logic [6:0] mask_o;
    logic       irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    exp_t q[$];
    logic [7:0] m_flags;
    logic [6:0] m_mask;
    logic       m_irq;

    always #10 clk = ~clk;

    irq_flag_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .flags_o(flags_o),
        .mask_o(mask_o), .irq_o(irq_o)
    );

    function automatic void compare(exp_t e);
        n_cmp++;
        if (flags_o !== e.flags || mask_o !== e.mask || irq_o !== e.irq) begin
            n_bad++;
            $display("FAIL %s: flags=%h mask=%h irq=%b expected flags=%h mask=%h irq=%b",
                     e.tag, flags_o, mask_o, irq_o, e.flags, e.mask, e.irq);
        end
    endfunction

    // Driver: apply one cycle of stimulus, push the expected post-edge state.
    task automatic step(input logic [7:0] ev, input logic we, input logic sel,
                        input logic [7:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        evt_i = ev; wr_en = we; wr_sel = sel; wr_data = d;
        e.irq   = |(m_flags[7:1] & m_mask);
        e.flags = (m_flags & ~((we && !sel) ? d : 8'h00)) | ev;
        e.mask  = (we && sel) ? d[6:0] : m_mask;
        e.tag   = tag;
        m_flags = e.flags; m_mask = e.mask; m_irq = e.irq;
        q.push_back(e);
    endtask

    // Monitor: five ns after each edge, compare against the queued item.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) compare(q.pop_front());
        end
    end

    initial begin
        #(200000 * 20);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        exp_t r;
        m_flags = 8'h01; m_mask = 7'h7F; m_irq = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        r.flags = 8'h01; r.mask = 7'h7F; r.irq = 1'b0; r.tag = "R1 reset state";
        compare(r);

        step(8'h00, 0, 0, 8'h00, "R7 restart flag alone keeps pin low");
        step(8'h00, 0, 0, 8'h00, "R7 restart flag alone keeps pin low");
        step(8'h00, 1, 0, 8'h01, "R3 write-one clears restart flag");
        step(8'h04, 0, 0, 8'h00, "R2 RDM event sets bit 2");
        step(8'h00, 0, 0, 8'h00, "R6 pin rises one edge after flag");
        step(8'h00, 0, 0, 8'h00, "R2 flag stays set");
        step(8'h00, 1, 0, 8'h00, "R3 zero write leaves flags");
        step(8'h00, 0, 1, 8'h04, "R8 disabled write ignored");
        step(8'h00, 1, 1, 8'h00, "R5 mask cleared");
        step(8'h00, 0, 0, 8'h00, "R6 pin drops after mask clear");
        step(8'h00, 1, 1, 8'hFF, "R5 mask load, bit 7 ignored");
        step(8'h04, 1, 0, 8'h04, "R4 set wins over clear");
        step(8'h00, 0, 0, 8'h00, "R4 flag still set");
        step(8'h00, 1, 0, 8'hFF, "R3 clear all flags");
        step(8'h00, 0, 0, 8'h00, "R6 pin drops after clear");
        step(8'h01, 0, 0, 8'h00, "R7 restart event with full mask");
        step(8'h00, 0, 0, 8'h00, "R7 pin stays low");
        step(8'h00, 1, 0, 8'h01, "R3 clear restart");

        for (int k = 1; k < 8; k++) begin
            step(8'h00, 1, 1, 8'(1 << (k - 1)), "R5 single mask bit");
            step(8'(1 << k), 0, 0, 8'h00, "R2 event on matching flag");
            step(8'h00, 0, 0, 8'h00, "R5 offset mask raises pin");
            step(8'h00, 1, 1, 8'(~(1 << (k - 1))), "R5 mismatched mask bits only");
            step(8'h00, 0, 0, 8'h00, "R5 pin low with other bits");
            step(8'h00, 1, 0, 8'(1 << k), "R3 clear flag");
        end
        step(8'h00, 0, 0, 8'h00, "R8 idle");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule